// File: doc/BRIEF.md
# Dual-Channel Power Capture Streamer

This block sits beside a triggered transmitter. It takes two complex sample streams: the samples being sent to the radio front end and the samples coming back from the receive path. For every sample period it works out the instantaneous power, the squared magnitude I² + Q², on both streams. It packs the two results into a single beat of an AXI4-Stream master interface, which carries them to the processor.

A start pulse opens a capture window. The window is measured in output beats and lasts N + (N >> 1) beats, where N is the transmit frame length. The extra half frame allows for the loop delay, so received energy that arrives after the last transmitted sample is still recorded. Once the transmit frame is over, the transmit half of each beat reads zero. Only receive power is reported during the padding.

The window controller has three states, named below with their transitions:
- `ST_IDLE` waits for a trigger. OPEN moves it to `ST_CAPTURE` when the trigger arrives with a non-zero length.
- `ST_CAPTURE` takes one beat per accepted receive sample. CLOSE moves it to `ST_DRAIN` when it takes the final beat.
- `ST_DRAIN` waits for that final beat to leave the output. RETIRE returns it to `ST_IDLE` when the final beat is accepted.

The squaring datapath has two register stages. The valid and last flags travel through the same two stages.

Top module: `pwr_capture_streamer`

## Requirements
- R1: After reset, `pwr_tvalid_o` and `pwr_tlast_o` are low and no beat is produced until a trigger opens a window.
- R2: A trigger with a non-zero `frame_len_i` = N opens a window of exactly W = N + floor(N/2) output beats. A trigger with N = 0 is ignored and produces no beat.
- R3: Each power value is the unsigned 32-bit sum I² + Q² of the signed 16-bit pair. The value −32768 on both I and Q gives 2^31 with no wrap.
- R4: Beat packing: `pwr_tdata_o[31:0]` holds the transmit power and `pwr_tdata_o[63:32]` holds the receive power of the same sample period.
- R5: A beat is taken in a cycle where the window is open, `rx_vld_i` is high and the output stage can advance. If `tx_vld_i` is low in that cycle, the transmit power of that beat is zero.
- R6: Beats with index N or more within the window (index 0 is the first beat) carry zero transmit power.
- R7: `pwr_tlast_o` is high on beat W−1 of the window and on no other beat.
- R8: While `pwr_tvalid_o` is high and `pwr_tready_i` is low, the beat (data and last) is held unchanged. No new sample is taken and the window count does not advance.
- R9: A trigger that arrives while a window is still open or draining is ignored. The window keeps its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Start pulse that opens a capture window |
| frame_len_i | input | 11 | Transmit frame length N, sampled at the trigger |
| tx_vld_i | input | 1 | Transmit sample valid |
| tx_re_i | input | 16 | Transmit in-phase sample, signed |
| tx_im_i | input | 16 | Transmit quadrature sample, signed |
| rx_vld_i | input | 1 | Receive sample valid; paces the window |
| rx_re_i | input | 16 | Receive in-phase sample, signed |
| rx_im_i | input | 16 | Receive quadrature sample, signed |
| pwr_tvalid_o | output | 1 | Output stream valid |
| pwr_tready_i | input | 1 | Output stream ready |
| pwr_tdata_o | output | 64 | Receive power in the upper half, transmit power in the lower half |
| pwr_tlast_o | output | 1 | Final beat of the window |

## Verification
The assertions assume a few things about the inputs:
- `frame_len_i` is only meaningful in the cycle the trigger is seen.
- The sample streams carry no backpressure of their own, so a sample presented while the output is stalled is simply not taken.
- The consumer may hold `pwr_tready_i` low for any number of cycles.

The stimulus keeps within these assumptions. It holds each sample on the inputs until the bench's own model of the take condition says it was consumed. It drives ready, receive-valid and transmit-valid from separate periodic patterns, so stalls, input gaps and transmit gaps fall at varied positions within each window. It sweeps every frame length from 1 to 12, and also the largest length, 2047.

// File: rtl/pwr_cap_pkg.sv
package pwr_cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_DRAIN   = 2'd2
    } win_state_e;

    localparam int unsigned CH_TX = 0;
    localparam int unsigned CH_RX = 1;
    localparam int unsigned N_CH  = 2;

endpackage

// File: rtl/pwr_sqmag.sv
module pwr_sqmag #(
    parameter int unsigned DW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_i,
    input  logic signed [DW-1:0]   re_i,
    input  logic signed [DW-1:0]   im_i,
    output logic [2*DW-1:0]        pwr_o
);
    localparam int unsigned PW = 2 * DW;

    logic signed [PW-1:0] re_x;
    logic signed [PW-1:0] im_x;
    logic signed [PW-1:0] re_sq;
    logic signed [PW-1:0] im_sq;
    logic [PW-1:0]        sq_re_q;
    logic [PW-1:0]        sq_im_q;
    logic [PW-1:0]        pwr_q;

    // widen before multiplying so that the full signed product is kept
    assign re_x  = $signed({{DW{re_i[DW-1]}}, re_i});
    assign im_x  = $signed({{DW{im_i[DW-1]}}, im_i});
    assign re_sq = re_x * re_x;
    assign im_sq = im_x * im_x;

    // stage 1: squares
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_re_q <= '0;
            sq_im_q <= '0;
        end else if (en_i) begin
            sq_re_q <= $unsigned(re_sq);
            sq_im_q <= $unsigned(im_sq);
        end
    end

    // stage 2: sum; each square is at most 2^(PW-2), so the sum fits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q <= '0;
        end else if (en_i) begin
            pwr_q <= sq_re_q + sq_im_q;
        end
    end

    assign pwr_o = pwr_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (pwr_q >= $past(sq_re_q)) && (pwr_q >= $past(sq_im_q))); // R3

endmodule

// File: rtl/pwr_window_fsm.sv
module pwr_window_fsm
    import pwr_cap_pkg::*;
#(
    parameter int unsigned LEN_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               rx_vld_i,
    input  logic               adv_i,
    input  logic               retire_i,
    output logic               take_o,
    output logic               pad_o,
    output logic               final_o,
    output win_state_e         state_o
);
    localparam int unsigned CNT_W = LEN_W + 1;

    win_state_e        st_q;
    win_state_e        st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  win_q;
    logic [CNT_W-1:0]  len_q;
    logic [CNT_W-1:0]  len_ext;
    logic              open_evt;
    logic              close_evt;
    logic              retire_evt;

    assign len_ext = {1'b0, len_i};

    // transition events
    always_comb begin
        open_evt   = (st_q == ST_IDLE) && trig_i && (len_i != '0);
        close_evt  = (st_q == ST_CAPTURE) && take_o && final_o;
        retire_evt = (st_q == ST_DRAIN) && retire_i;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (open_evt)   st_d = ST_CAPTURE;
            ST_CAPTURE: if (close_evt)  st_d = ST_DRAIN;
            ST_DRAIN:   if (retire_evt) st_d = ST_IDLE;
            default:                    st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // window length and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            win_q <= '0;
            len_q <= '0;
        end else if (open_evt) begin
            cnt_q <= '0;
            len_q <= len_ext;
            win_q <= len_ext + (len_ext >> 1);
        end else if (take_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        take_o  = 1'b0;
        pad_o   = 1'b0;
        final_o = 1'b0;
        unique case (st_q)
            ST_CAPTURE: begin
                take_o  = rx_vld_i && adv_i;
                pad_o   = (cnt_q >= len_q);
                final_o = (cnt_q == win_q - 1'b1);
            end
            ST_IDLE, ST_DRAIN: begin
                take_o  = 1'b0;
            end
            default: begin
                take_o  = 1'b0;
            end
        endcase
    end

    assign state_o = st_q;

    AST_OPEN_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && trig_i && len_i != '0) |=> (st_q == ST_CAPTURE && cnt_q == '0)); // R2
    AST_ZERO_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && len_i == '0) |=> (st_q == ST_IDLE)); // R2
    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CAPTURE) |-> (cnt_q < win_q)); // R2
    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CAPTURE && !adv_i) |=> $stable(cnt_q)); // R8
    AST_BUSY_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CAPTURE && trig_i && !take_o) |=> (st_q == ST_CAPTURE && $stable(cnt_q) && $stable(win_q))); // R9

endmodule

// File: rtl/pwr_beat_pipe.sv
module pwr_beat_pipe (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic last_i,
    input  logic tready_i,
    output logic adv_o,
    output logic tvalid_o,
    output logic tlast_o
);
    logic v1_q;
    logic l1_q;
    logic v2_q;
    logic l2_q;

    // the whole pipeline moves only when the output slot is free or drained
    assign adv_o = !v2_q || tready_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            l1_q <= 1'b0;
            v2_q <= 1'b0;
            l2_q <= 1'b0;
        end else if (adv_o) begin
            v1_q <= take_i;
            l1_q <= take_i && last_i;
            v2_q <= v1_q;
            l2_q <= l1_q;
        end
    end

    assign tvalid_o = v2_q;
    assign tlast_o  = l2_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (v2_q && !tready_i) |=> (v2_q && $stable(l2_q))); // R8
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        l2_q |-> v2_q); // R7

endmodule

// File: rtl/pwr_capture_streamer.sv
module pwr_capture_streamer
    import pwr_cap_pkg::*;
#(
    parameter int unsigned DW    = 16,
    parameter int unsigned LEN_W = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_i,
    input  logic [LEN_W-1:0]     frame_len_i,
    input  logic                 tx_vld_i,
    input  logic signed [DW-1:0] tx_re_i,
    input  logic signed [DW-1:0] tx_im_i,
    input  logic                 rx_vld_i,
    input  logic signed [DW-1:0] rx_re_i,
    input  logic signed [DW-1:0] rx_im_i,
    output logic                 pwr_tvalid_o,
    input  logic                 pwr_tready_i,
    output logic [4*DW-1:0]      pwr_tdata_o,
    output logic                 pwr_tlast_o
);
    localparam int unsigned PW = 2 * DW;

    logic              take;
    logic              pad;
    logic              final_beat;
    logic              adv;
    logic              retire;
    logic              tx_zero;
    win_state_e        win_state;

    logic signed [DW-1:0] ch_re  [N_CH];
    logic signed [DW-1:0] ch_im  [N_CH];
    logic [PW-1:0]        ch_pwr [N_CH];

    assign retire  = pwr_tvalid_o && pwr_tready_i && pwr_tlast_o;
    assign tx_zero = pad || !tx_vld_i;

    pwr_window_fsm #(
        .LEN_W (LEN_W)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig_i),
        .len_i    (frame_len_i),
        .rx_vld_i (rx_vld_i),
        .adv_i    (adv),
        .retire_i (retire),
        .take_o   (take),
        .pad_o    (pad),
        .final_o  (final_beat),
        .state_o  (win_state)
    );

    pwr_beat_pipe i_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (take),
        .last_i   (final_beat),
        .tready_i (pwr_tready_i),
        .adv_o    (adv),
        .tvalid_o (pwr_tvalid_o),
        .tlast_o  (pwr_tlast_o)
    );

    // transmit channel is forced to zero outside its frame or on a gap
    always_comb begin
        ch_re[CH_TX] = tx_zero ? '0 : tx_re_i;
        ch_im[CH_TX] = tx_zero ? '0 : tx_im_i;
        ch_re[CH_RX] = rx_re_i;
        ch_im[CH_RX] = rx_im_i;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        pwr_sqmag #(
            .DW (DW)
        ) i_sq (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (adv),
            .re_i  (ch_re[c]),
            .im_i  (ch_im[c]),
            .pwr_o (ch_pwr[c])
        );
        assign pwr_tdata_o[c*PW +: PW] = ch_pwr[c];
    end

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_tvalid_o && !pwr_tready_i) |=> $stable(pwr_tdata_o)); // R8
    AST_LAST_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_tvalid_o && pwr_tready_i && pwr_tlast_o) |=> (win_state == ST_IDLE)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (win_state == ST_IDLE) |-> !take); // R1

endmodule

// File: tb/test_pwr_capture_streamer.sv
module test_pwr_capture_streamer;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               trig;
    logic [10:0]        flen;
    logic               tx_vld;
    logic signed [15:0] tx_re;
    logic signed [15:0] tx_im;
    logic               rx_vld;
    logic signed [15:0] rx_re;
    logic signed [15:0] rx_im;
    logic               tvalid;
    logic               tready;
    logic [63:0]        tdata;
    logic               tlast;

    int n_cmp  = 0;
    int n_miss = 0;

    logic [31:0] exp_tx [0:4095];
    logic [31:0] exp_rx [0:4095];

    always #5 clk = ~clk;

    pwr_capture_streamer i_pwr_capture_streamer (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig),
        .frame_len_i  (flen),
        .tx_vld_i     (tx_vld),
        .tx_re_i      (tx_re),
        .tx_im_i      (tx_im),
        .rx_vld_i     (rx_vld),
        .rx_re_i      (rx_re),
        .rx_im_i      (rx_im),
        .pwr_tvalid_o (tvalid),
        .pwr_tready_i (tready),
        .pwr_tdata_o  (tdata),
        .pwr_tlast_o  (tlast)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic signed [15:0] sgen(input int k, input int salt);
        int v;
        if (k == 0) return -16'sd32768;
        if (k == 1) return 16'sd32767;
        v = (k * 7919 + salt * 104729) % 65536;
        return 16'(v - 32768);
    endfunction

    function automatic logic [31:0] pw(input logic signed [15:0] a, input logic signed [15:0] b);
        longint s;
        s = longint'(a) * longint'(a) + longint'(b) * longint'(b);
        return 32'(s);
    endfunction

    task automatic run_window(input int n, input int mode);
        int w, k, j, cyc;
        bit rdy, rxv, txv, held, hl;
        logic [63:0] hd;
        w = n + n / 2;
        k = 0; j = 0; cyc = 0; held = 1'b0; hd = '0; hl = 1'b0;
        @(negedge clk);
        trig = 1'b1; flen = 11'(n); rx_vld = 1'b0; tx_vld = 1'b0; tready = 1'b1;
        while (j < w && cyc < 8 * w + 40) begin
            @(negedge clk);
            cyc++;
            trig = 1'b0;
            if (held) begin
                check(tvalid && tdata == hd && tlast == hl, "R8 held beat",
                      longint'(tdata[31:0]), longint'(hd[31:0]));
            end
            unique case (mode)
                0: begin rdy = 1'b1; rxv = 1'b1; txv = 1'b1; end
                1: begin rdy = (cyc % 3) != 0; rxv = (cyc % 4) != 1; txv = 1'b1; end
                2: begin rdy = (cyc % 2) == 0; rxv = 1'b1; txv = (cyc % 5) != 2; end
                default: begin rdy = (cyc % 3) != 0; rxv = (cyc % 4) != 1; txv = (cyc % 3) != 1; end
            endcase
            if (mode == 3 && (cyc == 3 || cyc == 7)) begin
                trig = 1'b1;               // R9: retrigger while busy
                flen = 11'(n + 5);
            end
            tready = rdy; rx_vld = rxv; tx_vld = txv;
            tx_re = sgen(k, 1); tx_im = sgen(k, 2);
            rx_re = sgen(k, 3); rx_im = sgen(k, 4);
            if (tvalid && rdy) begin
                check(tdata[31:0] == exp_tx[j], (j >= n) ? "R6 tx pad power" : "R3 R4 R5 tx power",
                      longint'(tdata[31:0]), longint'(exp_tx[j]));
                check(tdata[63:32] == exp_rx[j], "R3 R4 rx power",
                      longint'(tdata[63:32]), longint'(exp_rx[j]));
                check(tlast == (j == w - 1), "R7 last flag", longint'(tlast), longint'(j == w - 1));
                j++;
            end
            held = tvalid && !rdy;
            hd = tdata; hl = tlast;
            if (k < w && rxv && (!tvalid || rdy)) begin
                exp_tx[k] = (k < n && txv) ? pw(tx_re, tx_im) : 32'd0;
                exp_rx[k] = pw(rx_re, rx_im);
                k++;
            end
        end
        check(j == w, "R2 window beat count", j, w);
        trig = 1'b0; tready = 1'b1; rx_vld = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!tvalid, "R2 R9 no beat after window", longint'(tvalid), 0);
        end
        rx_vld = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; trig = 1'b0; flen = '0; tx_vld = 1'b0; tx_re = '0; tx_im = '0;
        rx_vld = 1'b0; rx_re = '0; rx_im = '0; tready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tvalid && !tlast, "R1 reset outputs", longint'({tvalid, tlast}), 0);
        rx_vld = 1'b1;
        repeat (4) @(negedge clk);
        check(!tvalid, "R1 no beat without trigger", longint'(tvalid), 0);

        // R2: zero length trigger ignored
        trig = 1'b1; flen = '0;
        @(negedge clk);
        trig = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(!tvalid, "R2 zero length ignored", longint'(tvalid), 0);
        end
        rx_vld = 1'b0;

        // R3 corner: -32768 on I and Q gives 2^31
        check(pw(-16'sd32768, -16'sd32768) == 32'h8000_0000, "R3 bench corner model",
              longint'(pw(-16'sd32768, -16'sd32768)), 64'h8000_0000);

        for (int n = 1; n <= 12; n++) begin
            for (int m = 0; m < 4; m++) begin
                run_window(n, m);
            end
        end
        run_window(2047, 0);
        run_window(2047, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_miss++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

endmodule